// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 16-bit data-memory address for the load and store operations of a small 8-bit processor. A decoded operation arrives as a mode code, the instruction word and a pointer select. The block answers with a registered address and a one-cycle valid strobe. Three address sources exist. The first is a 7-bit field inside a single-word instruction, which reaches only the lowest 128 bytes. The second is a full 16-bit address carried in the word that follows a two-word instruction. The third is one of three pointers, each made of two 8-bit registers taken from the top of the 32-entry register file.

The block holds its own copy of the six pointer registers. It snoops the register-file write port, which carries one 8-bit write per cycle, so a program sets up a pointer with two separate byte writes. For a two-word instruction the block spends one cycle collecting the second word on the instruction bus. During that cycle it raises no strobe and decodes nothing. A pointer select that names no pointer raises an error flag in place of the strobe. Any operation that is not a load or store leaves the strobe low.

Top module: `lsu_ea_gen`

## Requirements
- R1: After reset `ea_valid` and `ea_illegal` are low, `ea_addr` is zero and every pointer register reads as zero.
- R2: An accepted operation with `op_mode` = 2'b01 (short direct) gives `ea_valid` high in the next cycle, with `ea_addr` equal to `instr_word[6:0]` zero-extended. Bits 15..7 of the word have no effect.
- R3: An accepted operation with `op_mode` = 2'b10 (long direct) keeps `ea_valid` low in the next cycle. In that cycle the bus carries the second word, and one cycle later `ea_valid` is high with `ea_addr` equal to that second word.
- R4: In the cycle that collects the second word, `op_valid`, `op_mode` and `ptr_sel` are ignored, so only one strobe results.
- R5: An accepted operation with `op_mode` = 2'b11 (pointer) gives `ea_valid` high in the next cycle. `ptr_sel` 0 selects registers 26/27, 1 selects 28/29 and 2 selects 30/31. The even register supplies `ea_addr[7:0]` and the odd register supplies `ea_addr[15:8]`.
- R6: A pointer operation with `ptr_sel` = 2'b11 raises `ea_illegal` for one cycle and keeps `ea_valid` low. `ea_valid` and `ea_illegal` are never high together.
- R7: With `op_valid` low, or with `op_mode` = 2'b00 (not a memory operation), neither `ea_valid` nor `ea_illegal` rises in the next cycle.
- R8: A pointer read in the same cycle as a write to one of its registers uses the value held before that write.
- R9: A write with `rf_we` high changes only the register at `rf_waddr`. Writing one half of a pair leaves the other half unchanged.
- R10: `ea_addr` keeps its value in every cycle in which `ea_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | A decoded operation is present |
| op_mode | input | 2 | 00 none, 01 short direct, 10 long direct, 11 pointer |
| instr_word | input | 16 | Instruction word; the second word in the cycle after a long direct |
| ptr_sel | input | 2 | Pointer pair select; 3 is reserved |
| rf_we | input | 1 | Register-file write enable |
| rf_waddr | input | 5 | Register-file write index |
| rf_wdata | input | 8 | Register-file write byte |
| ea_addr | output | 16 | Effective address |
| ea_valid | output | 1 | Address strobe, one cycle per address |
| ea_illegal | output | 1 | Reserved pointer select was used |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit registers, 32 register indices, a 7-bit short field and three pairs based at register 26. These values let the bench name every pointer register directly. They also let it aim random writes at indices 24 to 31, so writes to non-pointer registers, writes that collide with a pointer read and split-byte updates all occur often. Random short words with bits set above bit 6 exercise the zero extension. Random long operations land second words that themselves look like operations, which is the case the wait cycle must ignore.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    EA_NONE  = 2'd0,
    EA_SHORT = 2'd1,
    EA_LONG  = 2'd2,
    EA_PTR   = 2'd3
  } ea_mode_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_EXT  = 1'b1
  } seq_state_e;

  localparam logic [1:0] PSEL_RSVD = 2'd3;

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/ea_ptr_bank.sv
module ea_ptr_bank #(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 32,
  parameter int PTR_BASE  = 26,
  parameter int NUM_PTRS  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [$clog2(REG_COUNT)-1:0]       waddr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_PTRS*2*DATA_W-1:0]       ptr_flat
);

  localparam int RIDX_W = $clog2(REG_COUNT);
  localparam int NCELL  = NUM_PTRS * 2;
  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] cell_q [NCELL];
  logic [DATA_W-1:0] cell_d [NCELL];
  logic [NCELL-1:0]  hit;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    assign hit[k] = we && (waddr == RIDX_W'(PTR_BASE + k));

    always_comb begin
      cell_d[k] = cell_q[k];
      if (hit[k]) begin
        cell_d[k] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[k] <= '0;
      end else if (hit[k]) begin
        cell_q[k] <= cell_d[k];
      end
    end

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RIDX_W'(PTR_BASE + k)) |=> (cell_q[k] == $past(wdata))); // R9
    AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == RIDX_W'(PTR_BASE + k)) |=> $stable(cell_q[k])); // R9
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_pair
    assign ptr_flat[p*PAIR_W +: PAIR_W] = {cell_q[2*p+1], cell_q[2*p]};
  end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  ea_mode_e   op_mode,
  input  logic [1:0] ptr_sel,
  output logic       take_short,
  output logic       take_ptr,
  output logic       take_ext,
  output logic       start_long,
  output logic       flag_illegal,
  output logic       waiting
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       accept;
  logic       ptr_go;

  always_comb begin
    waiting      = (state_q == SQ_EXT);
    take_ext     = waiting;
    accept       = op_valid && (state_q == SQ_IDLE);
    take_short   = accept && (op_mode == EA_SHORT);
    start_long   = accept && (op_mode == EA_LONG);
    ptr_go       = accept && (op_mode == EA_PTR);
    take_ptr     = ptr_go && (ptr_sel != PSEL_RSVD);
    flag_illegal = ptr_go && (ptr_sel == PSEL_RSVD);

    state_d = state_q;
    if (take_ext) begin
      state_d = SQ_IDLE;
    end else if (start_long) begin
      state_d = SQ_EXT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_EXT) |=> (state_q == SQ_IDLE)); // R4
  AST_LONG_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == EA_LONG && state_q == SQ_IDLE) |=> (state_q == SQ_EXT)); // R3

endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 32,
  parameter int SHORT_W   = 7,
  parameter int PTR_BASE  = 26,
  parameter int NUM_PTRS  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [1:0]                   op_mode,
  input  logic [ADDR_W-1:0]            instr_word,
  input  logic [1:0]                   ptr_sel,
  input  logic                         rf_we,
  input  logic [$clog2(REG_COUNT)-1:0] rf_waddr,
  input  logic [DATA_W-1:0]            rf_wdata,
  output logic [ADDR_W-1:0]            ea_addr,
  output logic                         ea_valid,
  output logic                         ea_illegal
);

  localparam int PAIR_W = 2 * DATA_W;

  logic                       srst_n;
  logic [NUM_PTRS*PAIR_W-1:0] ptr_flat;
  logic                       take_short;
  logic                       take_ptr;
  logic                       take_ext;
  logic                       start_long;
  logic                       flag_illegal;
  logic                       waiting;
  logic [PAIR_W-1:0]          ptr_word;
  logic [ADDR_W-1:0]          addr_d;
  logic [ADDR_W-1:0]          addr_q;
  logic                       addr_en;
  logic                       valid_d;
  logic                       valid_q;
  logic                       ill_d;
  logic                       ill_q;
  ea_mode_e                   mode;

  assign mode = ea_mode_e'(op_mode);

  ea_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ea_ptr_bank #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT),
    .PTR_BASE  (PTR_BASE),
    .NUM_PTRS  (NUM_PTRS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .ptr_flat (ptr_flat)
  );

  ea_seq u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .op_valid     (op_valid),
    .op_mode      (mode),
    .ptr_sel      (ptr_sel),
    .take_short   (take_short),
    .take_ptr     (take_ptr),
    .take_ext     (take_ext),
    .start_long   (start_long),
    .flag_illegal (flag_illegal),
    .waiting      (waiting)
  );

  always_comb begin
    ptr_word = '0;
    for (int p = 0; p < NUM_PTRS; p++) begin
      if (ptr_sel == 2'(p)) begin
        ptr_word = ptr_flat[p*PAIR_W +: PAIR_W];
      end
    end
  end

  always_comb begin
    addr_en = take_short || take_ptr || take_ext;
    valid_d = addr_en;
    ill_d   = flag_illegal;
    if (take_ext) begin
      addr_d = instr_word;
    end else if (take_short) begin
      addr_d = ADDR_W'(instr_word[SHORT_W-1:0]);
    end else begin
      addr_d = ADDR_W'(ptr_word);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ill_q   <= ill_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign ea_addr    = addr_q;
  assign ea_valid   = valid_q;
  assign ea_illegal = ill_q;

  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && mode == EA_SHORT && !waiting) |=>
      (ea_valid && ea_addr[ADDR_W-1:SHORT_W] == '0
       && ea_addr[SHORT_W-1:0] == $past(instr_word[SHORT_W-1:0]))); // R2
  AST_LONG_GAP: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && mode == EA_LONG && !waiting) |=> !ea_valid); // R3
  AST_LONG_CAPTURE: assert property (@(posedge clk) disable iff (!srst_n)
    waiting |=> (ea_valid && ea_addr == $past(instr_word))); // R3
  AST_RSVD_SEL: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && mode == EA_PTR && ptr_sel == PSEL_RSVD && !waiting) |=>
      (ea_illegal && !ea_valid)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(ea_valid && ea_illegal)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    ((!op_valid || mode == EA_NONE) && !waiting) |=> (!ea_valid && !ea_illegal)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !ea_valid |-> (ea_addr == $past(ea_addr))); // R10

endmodule

// File: tb/sim_lsu_ea_gen.sv
module sim_lsu_ea_gen;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_mode;
  logic [15:0] instr_word;
  logic [1:0]  ptr_sel;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [7:0]  rf_wdata;
  logic [15:0] ea_addr;
  logic        ea_valid;
  logic        ea_illegal;

  int    n_vec;
  int    n_bad;
  string cur_req;
  bit    cmp_on;

  logic [7:0]  m_reg [32];
  bit          m_wait;
  bit          m_v;
  bit          m_ill;
  logic [15:0] m_addr;

  lsu_ea_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_mode    (op_mode),
    .instr_word (instr_word),
    .ptr_sel    (ptr_sel),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .ea_addr    (ea_addr),
    .ea_valid   (ea_valid),
    .ea_illegal (ea_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
      m_wait = 0; m_v = 0; m_ill = 0; m_addr = 16'h0000;
    end else begin
      bit nv;
      bit nill;
      int base;
      nv = 0; nill = 0;
      if (m_wait) begin
        m_addr = instr_word; nv = 1; m_wait = 0;
      end else if (op_valid) begin
        case (op_mode)
          2'd1: begin m_addr = {9'd0, instr_word[6:0]}; nv = 1; end
          2'd2: m_wait = 1;
          2'd3: begin
            if (ptr_sel == 2'd3) nill = 1;
            else begin
              base = 26 + 2 * int'(ptr_sel);
              m_addr = {m_reg[base+1], m_reg[base]};
              nv = 1;
            end
          end
          default: ;
        endcase
      end
      if (rf_we) m_reg[rf_waddr] = rf_wdata;
      m_v = nv; m_ill = nill;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_vec++;
      if (ea_valid !== m_v || ea_illegal !== m_ill || ea_addr !== m_addr) begin
        n_bad++;
        $display("FAIL %s model: valid/illegal/addr actual %0b/%0b/%h expected %0b/%0b/%h",
                 cur_req, ea_valid, ea_illegal, ea_addr, m_v, m_ill, m_addr);
      end
    end
  end

  task automatic cyc(input bit ov, input logic [1:0] md, input logic [15:0] w,
                     input logic [1:0] sel, input bit we, input logic [4:0] wa,
                     input logic [7:0] wd);
    @(negedge clk);
    op_valid = ov; op_mode = md; instr_word = w; ptr_sel = sel;
    rf_we = we; rf_waddr = wa; rf_wdata = wd;
  endtask

  task automatic idle();
    cyc(0, 2'd0, 16'h0000, 2'd0, 0, 5'd0, 8'h00);
  endtask

  task automatic wr(input logic [4:0] wa, input logic [7:0] wd);
    cyc(0, 2'd0, 16'h0000, 2'd0, 1, wa, wd);
  endtask

  task automatic peek(input bit ev, input bit ei, input logic [15:0] ea, input string tag);
    n_vec++;
    if (ea_valid !== ev || ea_illegal !== ei || ea_addr !== ea) begin
      n_bad++;
      $display("FAIL %s directed: valid/illegal/addr actual %0b/%0b/%h expected %0b/%0b/%h",
               tag, ea_valid, ea_illegal, ea_addr, ev, ei, ea);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; cmp_on = 0; cur_req = "R1";
    rst_n = 1'b0;
    op_valid = 0; op_mode = 0; instr_word = 0; ptr_sel = 0;
    rf_we = 0; rf_waddr = 0; rf_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    cmp_on = 1;

    // R1: reset state, pointers read as zero
    peek(0, 0, 16'h0000, "R1");
    cyc(1, 2'd3, 16'h0000, 2'd2, 0, 5'd0, 8'h00);
    idle(); peek(1, 0, 16'h0000, "R1");

    // R2: short direct, upper bits have no effect
    cur_req = "R2";
    cyc(1, 2'd1, 16'hFFAB, 2'd0, 0, 5'd0, 8'h00);
    idle(); peek(1, 0, 16'h002B, "R2");
    cyc(1, 2'd1, 16'h007F, 2'd0, 0, 5'd0, 8'h00);
    idle(); peek(1, 0, 16'h007F, "R2");

    // R5: pairs, even byte low, odd byte high
    cur_req = "R5";
    wr(5'd26, 8'h34); wr(5'd27, 8'h12);
    wr(5'd28, 8'h78); wr(5'd29, 8'h56);
    wr(5'd30, 8'hBC); wr(5'd31, 8'h9A);
    wr(5'd25, 8'hFF);
    cyc(1, 2'd3, 16'h0000, 2'd0, 0, 5'd0, 8'h00);
    cyc(1, 2'd3, 16'h0000, 2'd1, 0, 5'd0, 8'h00); peek(1, 0, 16'h1234, "R5");
    cyc(1, 2'd3, 16'h0000, 2'd2, 0, 5'd0, 8'h00); peek(1, 0, 16'h5678, "R5");
    idle(); peek(1, 0, 16'h9ABC, "R5");

    // R9: one half written, other half kept
    cur_req = "R9";
    wr(5'd26, 8'hEE);
    cyc(1, 2'd3, 16'h0000, 2'd0, 0, 5'd0, 8'h00);
    idle(); peek(1, 0, 16'h12EE, "R9");

    // R8: read and write of the same pair in one cycle
    cur_req = "R8";
    cyc(1, 2'd3, 16'h0000, 2'd0, 1, 5'd27, 8'h00);
    cyc(1, 2'd3, 16'h0000, 2'd0, 0, 5'd0, 8'h00); peek(1, 0, 16'h12EE, "R8");
    idle(); peek(1, 0, 16'h00EE, "R8");

    // R6 and R10: reserved select, address held
    cur_req = "R6";
    cyc(1, 2'd3, 16'h0000, 2'd3, 0, 5'd0, 8'h00);
    idle(); peek(0, 1, 16'h00EE, "R6");
    idle(); peek(0, 0, 16'h00EE, "R10");

    // R3: two-word direct
    cur_req = "R3";
    cyc(1, 2'd2, 16'h1111, 2'd0, 0, 5'd0, 8'h00);
    cyc(0, 2'd0, 16'hBEEF, 2'd0, 0, 5'd0, 8'h00); peek(0, 0, 16'h00EE, "R3");
    idle(); peek(1, 0, 16'hBEEF, "R3");

    // R4: second word looks like an operation and is not decoded
    cur_req = "R4";
    cyc(1, 2'd2, 16'h2222, 2'd0, 0, 5'd0, 8'h00);
    cyc(1, 2'd3, 16'hC001, 2'd3, 0, 5'd0, 8'h00); peek(0, 0, 16'hBEEF, "R4");
    idle(); peek(1, 0, 16'hC001, "R4");
    idle(); peek(0, 0, 16'hC001, "R4");

    // R7: non-memory operation
    cur_req = "R7";
    cyc(1, 2'd0, 16'h0055, 2'd1, 0, 5'd0, 8'h00);
    idle(); peek(0, 0, 16'hC001, "R7");

    // random traffic, compared against the reference every cycle (R5 R3 R8)
    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] wa;
      wa = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(24, 31));
      cyc(1'($urandom_range(0, 1)), 2'($urandom), 16'($urandom), 2'($urandom),
          1'($urandom_range(0, 1)), wa, 8'($urandom));
    end
    idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule